// File: doc/BRIEF.md
# Switch-on-Miss Thread Controller

This block steers a single in-order pipeline between hardware thread contexts using coarse-grain multithreading. The running thread keeps the pipeline until it takes a long-latency cache miss. At that point the controller pulses a flush, so that no work from the stalled thread stays in flight. It records the stalled thread as waiting and hands fetch to another thread that is ready. Each switch is followed by a fixed refill penalty, and no fetch takes place during it.

When no thread is ready, the controller idles the pipeline with fetch held off. The first thread whose miss data comes back is resumed, after the same penalty. The block holds no program counters and no datapath. It produces only the selected thread number, the flush pulse, the fetch enable and the per-thread waiting flags. Thread count and penalty length are parameters; the defaults are two threads and a four-cycle penalty.

Top module: `swm_thread_ctrl`

## Requirements
- R1: After reset, thread 0 is selected, no thread is waiting, flush is low and fetch enable is high.
- R2: A miss on the selected thread, sampled while fetch enable is high, raises flush for exactly one cycle, in the cycle after the sampling edge. In that same cycle the thread's waiting bit is set and the selection moves to the next ready thread in rotating order.
- R3: Fetch enable stays low for exactly PENALTY cycles (4 by default), starting with the flush cycle. It is high in the cycle that follows.
- R4: A waiting thread is never selected while it is running. Its waiting bit clears in the cycle after its miss-return event.
- R5: If no other thread is ready when the selected thread misses, flush still pulses and the waiting bit is set. The selection is left unchanged and fetch enable stays low while every thread is waiting.
- R6: While idle, a miss-return selects the returning thread in the next cycle, with no flush, and fetch then stays low for PENALTY cycles. If several threads return in the same cycle, the lowest-numbered thread wins.
- R7: Miss events from a thread that is not selected are ignored, and so are all miss events while the pipeline is idle. An ignored miss produces no flush, no change of selection and no change of waiting bits.
- R8: A miss on the selected thread during the penalty window is held back. In the first cycle after the window, fetch stays low. The switch is then made at the end of that cycle, and flush appears in the cycle after it.
- R9: A miss-return for a thread that is not waiting has no effect. A return that arrives in the same cycle as a switch decision makes that thread eligible for the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_i | input | NTHR | Long-latency miss event, one bit per thread |
| ret_i | input | NTHR | Miss-return event, one bit per thread |
| active_tid_o | output | TID_W | Currently selected thread |
| flush_o | output | 1 | One-cycle pipeline flush pulse |
| fetch_en_o | output | 1 | Fetch may proceed for the selected thread |
| waiting_o | output | NTHR | Per-thread waiting flag |

## Verification
The hardest situation to reach is a miss that lands inside the refill window. Its outcome depends on the exact offset from the previous switch, and it interacts with whether the other thread is still waiting. The bench sweeps the offset of that second miss over every cycle of the window and a few cycles beyond it, and checks the flush cycle against max(offset, PENALTY+1)+1. It also drives a return in the same cycle as a switch decision, and simultaneous returns while idle, to reach the tie and race cases.

// File: rtl/swm_pkg.sv
package swm_pkg;
   typedef enum logic {
      MODE_IDLE = 1'b0,
      MODE_RUN  = 1'b1
   } swm_mode_e;
endpackage

// File: rtl/swm_rr_pick.sv
module swm_rr_pick #(
   parameter int NTHR  = 2,
   parameter int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
   input  logic [NTHR-1:0]  req_i,
   input  logic [TID_W-1:0] start_i,
   output logic             found_o,
   output logic [TID_W-1:0] tid_o
);
   generate
      if (NTHR == 2) begin : g_pair
         always_comb begin
            found_o = |req_i;
            tid_o   = req_i[start_i] ? start_i : ~start_i;
         end
      end else begin : g_rotate
         always_comb begin
            found_o = 1'b0;
            tid_o   = '0;
            for (int i = NTHR - 1; i >= 0; i--) begin
               if (req_i[(int'(start_i) + i) % NTHR]) begin
                  found_o = 1'b1;
                  tid_o   = TID_W'((int'(start_i) + i) % NTHR);
               end
            end
         end
      end
   endgenerate

   always_comb begin
      if (found_o) assert_pick_is_request_R2 : assert (req_i[tid_o]);
   end
endmodule

// File: rtl/swm_penalty_timer.sv
module swm_penalty_timer #(
   parameter int PENALTY = 4,
   localparam int CNT_W  = $clog2(PENALTY + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= CNT_W'(PENALTY);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

   assert_timer_bounded_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(PENALTY));
   assert_timer_counts_down_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/swm_thread_ctrl.sv
module swm_thread_ctrl
   import swm_pkg::*;
#(
   parameter int NTHR    = 2,
   parameter int PENALTY = 4,
   localparam int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NTHR-1:0]  miss_i,
   input  logic [NTHR-1:0]  ret_i,
   output logic [TID_W-1:0] active_tid_o,
   output logic             flush_o,
   output logic             fetch_en_o,
   output logic [NTHR-1:0]  waiting_o
);
   initial begin
      assert_param_threads_R2 : assert (NTHR >= 2);
      assert_param_penalty_R3 : assert (PENALTY >= 1);
   end

   swm_mode_e        mode_q, mode_n;
   logic [TID_W-1:0] act_q, act_n;
   logic [NTHR-1:0]  wait_q, wait_n;
   logic             flush_q, flush_n;
   logic             defer_q, defer_n;
   logic             busy, load;
   logic             run, miss_act, trig, defer_set;
   logic [NTHR-1:0]  act_onehot, avail, resume_req;
   logic [TID_W-1:0] act_next_start;
   logic             sw_found, rs_found;
   logic [TID_W-1:0] sw_tid, rs_tid;

   swm_penalty_timer #(.PENALTY(PENALTY)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(load),
      .busy_o(busy)
   );

   always_comb begin
      run            = (mode_q == MODE_RUN);
      act_onehot     = NTHR'(1) << act_q;
      miss_act       = run && miss_i[act_q];
      trig           = run && !busy && (miss_act || defer_q);
      defer_set      = run && busy && miss_act;
      avail          = (~wait_q | ret_i) & ~act_onehot;
      resume_req     = ret_i & wait_q;
      act_next_start = (int'(act_q) == NTHR - 1) ? '0 : act_q + 1'b1;
   end

   swm_rr_pick #(.NTHR(NTHR), .TID_W(TID_W)) i_switch_pick (
      .req_i  (avail),
      .start_i(act_next_start),
      .found_o(sw_found),
      .tid_o  (sw_tid)
   );

   swm_rr_pick #(.NTHR(NTHR), .TID_W(TID_W)) i_resume_pick (
      .req_i  (resume_req),
      .start_i('0),
      .found_o(rs_found),
      .tid_o  (rs_tid)
   );

   always_comb begin
      mode_n  = mode_q;
      act_n   = act_q;
      wait_n  = wait_q & ~ret_i;
      flush_n = 1'b0;
      defer_n = defer_q;
      load    = 1'b0;
      if (trig) begin
         wait_n  = wait_n | act_onehot;
         flush_n = 1'b1;
         defer_n = 1'b0;
         if (sw_found) begin
            act_n = sw_tid;
            load  = 1'b1;
         end else begin
            mode_n = MODE_IDLE;
         end
      end else if (defer_set) begin
         defer_n = 1'b1;
      end else if (!run && rs_found) begin
         mode_n = MODE_RUN;
         act_n  = rs_tid;
         load   = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= MODE_RUN;
         act_q   <= '0;
         wait_q  <= '0;
         flush_q <= 1'b0;
         defer_q <= 1'b0;
      end else begin
         mode_q  <= mode_n;
         act_q   <= act_n;
         wait_q  <= wait_n;
         flush_q <= flush_n;
         defer_q <= defer_n;
      end
   end

   assign active_tid_o = act_q;
   assign flush_o      = flush_q;
   assign fetch_en_o   = run && !busy && !defer_q;
   assign waiting_o    = wait_q;

   assert_flush_single_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> !flush_o);
   assert_miss_marks_wait_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> waiting_o[$past(act_q)]);
   assert_flush_stops_fetch_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> !fetch_en_o);
   assert_running_not_waiting_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      run |-> !waiting_o[active_tid_o]);
   assert_all_wait_no_fetch_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (&waiting_o) |-> !fetch_en_o);
   assert_resume_no_flush_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!run && rs_found) |=> (!flush_o && !fetch_en_o));
   assert_idle_miss_ignored_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !rs_found) |=> ($stable(active_tid_o) && !flush_o));
   assert_deferred_holds_fetch_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      defer_set |=> !fetch_en_o);
endmodule

// File: tb/test_swm_thread_ctrl.sv
module test_swm_thread_ctrl;
   localparam int NTHR = 2;
   localparam int PEN  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] miss = '0;
   logic [1:0] ret = '0;
   logic [0:0] act;
   logic       flush, fetch_en;
   logic [1:0] waiting;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   swm_thread_ctrl #(.NTHR(NTHR), .PENALTY(PEN)) i_swm_thread_ctrl (
      .clk(clk), .rst_n(rst_n), .miss_i(miss), .ret_i(ret),
      .active_tid_o(act), .flush_o(flush), .fetch_en_o(fetch_en), .waiting_o(waiting)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   task automatic do_reset();
      miss = '0; ret = '0; rst_n = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      chk("R1 active", act, 0);
      chk("R1 waiting", waiting, 0);
      chk("R1 flush", flush, 0);
      chk("R1 fetch_en", fetch_en, 1);

      // R7: miss from the thread that is not selected
      miss = 2'b10; tick(); miss = '0;
      chk("R7 flush", flush, 0);
      chk("R7 active", act, 0);
      chk("R7 waiting", waiting, 0);

      // R2/R3: switch from thread 0 to thread 1
      miss = 2'b01; tick(); miss = '0;
      chk("R2 flush", flush, 1);
      chk("R2 active", act, 1);
      chk("R2 waiting", waiting, 1);
      chk("R3 fetch c1", fetch_en, 0);
      for (int c = 2; c <= PEN; c++) begin
         tick();
         chk("R3 fetch low", fetch_en, 0);
         chk("R2 flush single", flush, 0);
      end
      tick();
      chk("R3 fetch restored", fetch_en, 1);

      // r9_: return for a thread that is not waiting
      ret = 2'b10; tick(); ret = '0;
      chk("R9 waiting unchanged", waiting, 1);
      chk("R9 active unchanged", act, 1);

      // R4: return clears waiting
      ret = 2'b01; tick(); ret = '0;
      chk("R4 waiting cleared", waiting, 0);

      // R5: switch to 0, then 0 misses while 1 waits -> idle
      miss = 2'b10; tick(); miss = '0;
      chk("R4 switch to 0", act, 0);
      chk("R4 waiting 1", waiting, 2);
      repeat (PEN) tick();
      chk("R3 fetch back", fetch_en, 1);
      miss = 2'b01; tick(); miss = '0;
      chk("R5 flush", flush, 1);
      chk("R5 active kept", act, 0);
      chk("R5 waiting all", waiting, 3);
      chk("R5 fetch off", fetch_en, 0);
      miss = 2'b01; tick();
      miss = 2'b10; tick(); miss = '0;
      chk("R7 idle miss flush", flush, 0);
      chk("R7 idle miss active", act, 0);
      repeat (3) tick();
      chk("R5 fetch stays off", fetch_en, 0);

      // R6: resume thread 1 from idle
      ret = 2'b10; tick(); ret = '0;
      chk("R6 active", act, 1);
      chk("R6 no flush", flush, 0);
      chk("R6 waiting", waiting, 1);
      begin
         int low = 1;
         while (!fetch_en && low < 20) begin tick(); if (!fetch_en) low++; end
         chk("R6 penalty length", low, PEN);
      end

      // R6: simultaneous returns while idle pick thread 0
      do_reset();
      miss = 2'b01; tick(); miss = '0;
      repeat (PEN) tick();
      miss = 2'b10; tick(); miss = '0;
      chk("R5 idle active", act, 1);
      chk("R5 idle waiting", waiting, 3);
      ret = 2'b11; tick(); ret = '0;
      chk("R6 tie lowest", act, 0);
      chk("R6 tie waiting", waiting, 0);

      // R9: return in the same cycle as the switch decision
      do_reset();
      miss = 2'b01; tick(); miss = '0;
      repeat (PEN) tick();
      miss = 2'b10; ret = 2'b01; tick(); miss = '0; ret = '0;
      chk("R9 same-cycle active", act, 0);
      chk("R9 same-cycle flush", flush, 1);
      chk("R9 same-cycle waiting", waiting, 2);

      // R8: sweep the offset of a second miss across the penalty window
      for (int k = 1; k <= 7; k++) begin
         int flush_at, fetch_c5, exp_at;
         do_reset();
         miss = 2'b01; tick(); miss = '0;
         flush_at = 0; fetch_c5 = -1;
         for (int cyc = 1; cyc <= 12; cyc++) begin
            miss = (cyc == k) ? 2'b10 : 2'b00;
            tick();
            miss = '0;
            if (cyc + 1 == PEN + 1) fetch_c5 = fetch_en;
            if (flush && flush_at == 0) flush_at = cyc + 1;
         end
         exp_at = ((k > PEN + 1) ? k : PEN + 1) + 1;
         chk($sformatf("R8 flush cycle k=%0d", k), flush_at, exp_at);
         chk($sformatf("R8 fetch after window k=%0d", k), fetch_c5, (k <= PEN) ? 0 : 1);
         chk($sformatf("R8 end waiting k=%0d", k), waiting, 3);
         chk($sformatf("R8 end fetch k=%0d", k), fetch_en, 0);
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule